// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order processor core. It splits every instruction into five steps: fetch, decode, execute, memory and writeback. An edge-triggered register sits between each pair of steps. The core runs a compact word-addressed instruction set with eight 32-bit general registers. The set has five instructions: two-operand add, bitwise nand, load word, store word and branch-if-equal.

The program, the reset contents of the register file and the reset contents of data memory are all fixed by parameters. Instruction memory and data memory live inside the core. The only ports are the clock, the reset and a set of debug taps. The taps show the PC, a writeback-occupied flag, any register and any data word.

The core has no hazard logic. It does not forward, stall or flush. Operands are read in decode and results are written in writeback. A taken branch steers the PC only when it is in the memory stage, so sequencing hazards is left to the program. One rule makes a three-instruction producer/consumer gap safe: when decode reads a register in the same cycle that writeback writes it, decode sees the new value.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` is 0, `dbg_retire` is 0, every register holds its `REG_INIT` word, every data word holds its `DMEM_INIT` word, and every pipeline register holds a noop.
- R2: An instruction word is decoded as follows.
  - Bits 24:22 are the opcode: add=000, nand=001, load=010, store=011, beq=100, noop=111.
  - Bits 21:19 name operand register A and bits 18:16 name operand register B.
  - Bits 2:0 are the destination for add and nand.
  - Bits 15:0 are a signed offset, sign-extended to 32 bits.
  - Any word whose opcode is 101 or 110, or whose bits 31:25 are not zero, behaves as a noop.
- R3: add writes A+B and nand writes ~(A&B) into the register named by bits 2:0.
- R4: load writes the data word at address A+offset into the register named by bits 18:16. Negative offsets are allowed. An address at or beyond `DMEM_DEPTH` reads as zero.
- R5: store writes B to the data word at address A+offset and writes no register. An address at or beyond `DMEM_DEPTH` is ignored.
- R6: beq compares A and B in execute. If they are equal, the branch target is PC+1+offset. If they differ, fetch continues in sequence.
- R7: A taken branch loads the PC when it is in the memory stage. For a beq fetched at edge j+1, `dbg_pc` equals the target after edge j+4. The three instructions that follow the beq in memory always complete.
- R8: The instruction fetched at rising edge j+1 after reset is released occupies writeback between edges j+4 and j+5, with `dbg_retire` high. Its register write lands at edge j+5. For a five-instruction program this means `dbg_retire` is still high after edge 8 and low after edge 9.
- R9: When writeback writes a register in the same cycle that decode reads it, decode gets the newly written value. This makes a gap of three instructions between producer and consumer correct.
- R10: A noop changes no register and no data word, and `dbg_retire` stays low while a noop is in writeback. A PC at or beyond `IMEM_DEPTH` fetches a noop, and the PC keeps counting.
- R11: `dbg_reg_data` and `dbg_mem_data` show, without a clock delay, the register and data word selected by `dbg_reg_sel` and `dbg_mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_reg_sel | input | 3 | Register index for the register debug tap |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_addr | input | clog2(DMEM_DEPTH) | Word index for the data memory debug tap |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| dbg_pc | output | 32 | Current fetch address |
| dbg_retire | output | 1 | High while a non-noop instruction is in writeback |

## Verification
Two functions can fall in the same cycle: writeback storing a result, and decode reading that same register for a younger instruction. The bench provokes this with a load followed three slots later by an add that consumes the loaded value. The add's result is then consumed three slots later again by a store. Both are judged at the ports: the add's destination and the stored data word are read through the taps after the program drains, and a stale operand shows up as a wrong value in either. A second collision puts a taken branch in the memory stage while three younger instructions are already in flight. It is judged by the PC value on the edge after the redirect and by which of the younger and skipped instructions left results.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int WORD_W  = 32;
    localparam int RIDX_W  = 3;
    localparam int OFF_W   = 16;

    // field positions fixed by the instruction format
    localparam int OPC_LSB = 22;
    localparam int RA_LSB  = 19;
    localparam int RB_LSB  = 16;
    localparam int RD_LSB  = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_NAND = 3'b001,
        OP_LW   = 3'b010,
        OP_SW   = 3'b011,
        OP_BEQ  = 3'b100,
        OP_NOOP = 3'b111
    } opcode_e;

    localparam logic [WORD_W-1:0] NOOP_WORD = {7'd0, 3'b111, 22'd0};

    typedef struct packed {
        logic [WORD_W-1:0] instr;
        logic [WORD_W-1:0] pc1;
    } ifid_t;

    typedef struct packed {
        opcode_e           op;
        logic [RIDX_W-1:0] rd_lo;
        logic [RIDX_W-1:0] rd_hi;
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] pc1;
    } idex_t;

    typedef struct packed {
        opcode_e           op;
        logic [RIDX_W-1:0] rd_lo;
        logic [RIDX_W-1:0] rd_hi;
        logic [WORD_W-1:0] alu;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] target;
        logic              eq;
    } exmem_t;

    typedef struct packed {
        opcode_e           op;
        logic [RIDX_W-1:0] rd_lo;
        logic [RIDX_W-1:0] rd_hi;
        logic [WORD_W-1:0] alu;
        logic [WORD_W-1:0] mdata;
    } memwb_t;

    // unknown opcodes and nonzero reserved bits collapse to a noop
    function automatic opcode_e decode_op(input logic [WORD_W-1:0] w);
        opcode_e r;
        r = OP_NOOP;
        if (w[WORD_W-1:OPC_LSB+3] == '0) begin
            unique case (w[OPC_LSB +: 3])
                3'b000:  r = OP_ADD;
                3'b001:  r = OP_NAND;
                3'b010:  r = OP_LW;
                3'b011:  r = OP_SW;
                3'b100:  r = OP_BEQ;
                default: r = OP_NOOP;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/pipe5_fetch.sv
module pipe5_fetch
    import pipe5_pkg::*;
#(
    parameter int                          IMEM_DEPTH = 32,
    parameter logic [IMEM_DEPTH*WORD_W-1:0] PROGRAM   = {IMEM_DEPTH{NOOP_WORD}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect_i,
    input  logic [WORD_W-1:0] target_i,
    output ifid_t             ifid_o,
    output logic [WORD_W-1:0] pc_o
);

    localparam int IA_W = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1;

    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] pc_inc;
    logic [WORD_W-1:0] rom_word;

    assign pc_inc = pc_q + WORD_W'(1);

    // instruction ROM built from the program parameter
    always_comb begin
        rom_word = NOOP_WORD;
        if (pc_q < WORD_W'(IMEM_DEPTH)) begin
            rom_word = PROGRAM[int'(pc_q[IA_W-1:0])*WORD_W +: WORD_W];
        end
    end

    // PC and IF/ID register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q         <= '0;
            ifid_o.instr <= NOOP_WORD;
            ifid_o.pc1   <= '0;
        end else begin
            pc_q         <= redirect_i ? target_i : pc_inc;
            ifid_o.instr <= rom_word;
            ifid_o.pc1   <= pc_inc;
        end
    end

    assign pc_o = pc_q;

    // a redirect lands the target in the PC on the next edge
    p_redirect_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> pc_q == $past(target_i));

    // in straight-line fetch, IF/ID's PC+1 and the PC agree
    p_pc1_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_i |=> ifid_o.pc1 == pc_q);

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int                  NREG = 8,
    parameter int                  W    = 32,
    parameter logic [NREG*W-1:0]   INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  ra_a_i,
    input  logic [$clog2(NREG)-1:0]  ra_b_i,
    output logic [W-1:0]             rd_a_o,
    output logic [W-1:0]             rd_b_o,
    input  logic                     we_i,
    input  logic [$clog2(NREG)-1:0]  wa_i,
    input  logic [W-1:0]             wd_i,
    input  logic [$clog2(NREG)-1:0]  dbg_sel_i,
    output logic [W-1:0]             dbg_o
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= INIT[i*W +: W];
            end
        end else if (we_i) begin
            regs[wa_i] <= wd_i;
        end
    end

    // write-through: a same-cycle write is visible to decode
    always_comb begin
        rd_a_o = (we_i && (wa_i == ra_a_i)) ? wd_i : regs[ra_a_i];
        rd_b_o = (we_i && (wa_i == ra_b_i)) ? wd_i : regs[ra_b_i];
    end

    assign dbg_o = regs[dbg_sel_i];

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> regs[$past(wa_i)] == $past(wd_i));

endmodule

// File: rtl/pipe5_dmem.sv
module pipe5_dmem #(
    parameter int                 DEPTH = 64,
    parameter int                 W     = 32,
    parameter logic [DEPTH*W-1:0] INIT  = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [W-1:0]              addr_i,
    input  logic [W-1:0]              wdata_i,
    output logic [W-1:0]              rdata_o,
    input  logic [$clog2(DEPTH)-1:0]  dbg_addr_i,
    output logic [W-1:0]              dbg_o
);

    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic          in_range;
    logic [AW-1:0] idx;

    assign in_range = addr_i < W'(DEPTH);
    assign idx      = addr_i[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= INIT[i*W +: W];
            end
        end else if (we_i && in_range) begin
            mem[idx] <= wdata_i;
        end
    end

    assign rdata_o = in_range ? mem[idx] : '0;
    assign dbg_o   = mem[dbg_addr_i];

    p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && in_range) |=> mem[$past(idx)] == $past(wdata_i));

endmodule

// File: rtl/pipe5_exec.sv
module pipe5_exec
    import pipe5_pkg::*;
(
    input  idex_t  idex_i,
    output exmem_t exmem_o
);

    always_comb begin
        exmem_o        = '0;
        exmem_o.op     = idex_i.op;
        exmem_o.rd_lo  = idex_i.rd_lo;
        exmem_o.rd_hi  = idex_i.rd_hi;
        exmem_o.b      = idex_i.b;
        exmem_o.target = idex_i.pc1 + idex_i.off;
        exmem_o.eq     = (idex_i.a == idex_i.b);
        unique case (idex_i.op)
            OP_ADD:        exmem_o.alu = idex_i.a + idex_i.b;
            OP_NAND:       exmem_o.alu = ~(idex_i.a & idex_i.b);
            OP_LW, OP_SW:  exmem_o.alu = idex_i.a + idex_i.off;
            default:       exmem_o.alu = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int                               IMEM_DEPTH = 32,
    parameter int                               DMEM_DEPTH = 64,
    parameter int                               NREG       = 1 << RIDX_W,
    parameter logic [IMEM_DEPTH*WORD_W-1:0]     PROGRAM    = {IMEM_DEPTH{NOOP_WORD}},
    parameter logic [NREG*WORD_W-1:0]           REG_INIT   = '0,
    parameter logic [DMEM_DEPTH*WORD_W-1:0]     DMEM_INIT  = '0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [RIDX_W-1:0]               dbg_reg_sel,
    output logic [WORD_W-1:0]               dbg_reg_data,
    input  logic [$clog2(DMEM_DEPTH)-1:0]   dbg_mem_addr,
    output logic [WORD_W-1:0]               dbg_mem_data,
    output logic [WORD_W-1:0]               dbg_pc,
    output logic                            dbg_retire
);

    ifid_t  ifid_q;
    idex_t  idex_d, idex_q;
    exmem_t exmem_d, exmem_q;
    memwb_t memwb_d, memwb_q;

    logic              redirect;
    logic [WORD_W-1:0] rf_a, rf_b;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic [WORD_W-1:0] rf_wd;
    logic              dm_we;
    logic [WORD_W-1:0] dm_rdata;

    // ---------------- fetch ----------------
    assign redirect = (exmem_q.op == OP_BEQ) && exmem_q.eq;

    pipe5_fetch #(
        .IMEM_DEPTH (IMEM_DEPTH),
        .PROGRAM    (PROGRAM)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .redirect_i (redirect),
        .target_i   (exmem_q.target),
        .ifid_o     (ifid_q),
        .pc_o       (dbg_pc)
    );

    // ---------------- decode ----------------
    pipe5_regfile #(
        .NREG (NREG),
        .W    (WORD_W),
        .INIT (REG_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_a_i    (ifid_q.instr[RA_LSB +: RIDX_W]),
        .ra_b_i    (ifid_q.instr[RB_LSB +: RIDX_W]),
        .rd_a_o    (rf_a),
        .rd_b_o    (rf_b),
        .we_i      (rf_we),
        .wa_i      (rf_wa),
        .wd_i      (rf_wd),
        .dbg_sel_i (dbg_reg_sel),
        .dbg_o     (dbg_reg_data)
    );

    always_comb begin
        idex_d.op    = decode_op(ifid_q.instr);
        idex_d.rd_lo = ifid_q.instr[RD_LSB +: RIDX_W];
        idex_d.rd_hi = ifid_q.instr[RB_LSB +: RIDX_W];
        idex_d.a     = rf_a;
        idex_d.b     = rf_b;
        idex_d.off   = {{(WORD_W-OFF_W){ifid_q.instr[OFF_W-1]}}, ifid_q.instr[OFF_W-1:0]};
        idex_d.pc1   = ifid_q.pc1;
    end

    // ---------------- execute ----------------
    pipe5_exec u_exec (
        .idex_i  (idex_q),
        .exmem_o (exmem_d)
    );

    // ---------------- memory ----------------
    assign dm_we = (exmem_q.op == OP_SW);

    pipe5_dmem #(
        .DEPTH (DMEM_DEPTH),
        .W     (WORD_W),
        .INIT  (DMEM_INIT)
    ) u_dmem (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (dm_we),
        .addr_i     (exmem_q.alu),
        .wdata_i    (exmem_q.b),
        .rdata_o    (dm_rdata),
        .dbg_addr_i (dbg_mem_addr),
        .dbg_o      (dbg_mem_data)
    );

    always_comb begin
        memwb_d.op    = exmem_q.op;
        memwb_d.rd_lo = exmem_q.rd_lo;
        memwb_d.rd_hi = exmem_q.rd_hi;
        memwb_d.alu   = exmem_q.alu;
        memwb_d.mdata = dm_rdata;
    end

    // ---------------- writeback ----------------
    always_comb begin
        rf_we = 1'b0;
        rf_wa = memwb_q.rd_lo;
        rf_wd = memwb_q.alu;
        unique case (memwb_q.op)
            OP_ADD, OP_NAND: rf_we = 1'b1;
            OP_LW: begin
                rf_we = 1'b1;
                rf_wa = memwb_q.rd_hi;
                rf_wd = memwb_q.mdata;
            end
            default: rf_we = 1'b0;
        endcase
    end

    assign dbg_retire = (memwb_q.op != OP_NOOP);

    // ---------------- stage registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_q      <= '0;
            idex_q.op   <= OP_NOOP;
            exmem_q     <= '0;
            exmem_q.op  <= OP_NOOP;
            memwb_q     <= '0;
            memwb_q.op  <= OP_NOOP;
        end else begin
            idex_q  <= idex_d;
            exmem_q <= exmem_d;
            memwb_q <= memwb_d;
        end
    end

    // an instruction leaving the memory stage is the next to occupy writeback
    p_stage_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_q.op != OP_NOOP) |=> (memwb_q.op == $past(exmem_q.op)));

    // noop, store and branch leave the register file untouched
    p_quiet_writeback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (memwb_q.op inside {OP_NOOP, OP_SW, OP_BEQ}) |-> !rf_we);

    // a taken branch in memory comes from an equal compare one edge earlier
    p_branch_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> ($past(idex_q.op) == OP_BEQ) && ($past(idex_q.a) == $past(idex_q.b)));

endmodule

// File: tb/test_pipe5_core.sv
module test_pipe5_core;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int IMD = 16;
    localparam int DMD = 64;
    localparam logic [31:0] NOP = {7'd0, 3'b111, 22'd0};

    function automatic logic [31:0] ins(input logic [2:0] op, input logic [2:0] ra,
                                        input logic [2:0] rb, input logic [15:0] f);
        return {7'd0, op, ra, rb, f};
    endfunction

    // sample program: add 1 2 3; nand 4 5 6; lw 2 4 20; add 2 5 5; sw 3 7 10
    function automatic logic [IMD*32-1:0] prog_a();
        logic [IMD*32-1:0] p;
        p = {IMD{NOP}};
        p[0*32 +: 32] = ins(3'b000, 3'd1, 3'd2, 16'd3);
        p[1*32 +: 32] = ins(3'b001, 3'd4, 3'd5, 16'd6);
        p[2*32 +: 32] = ins(3'b010, 3'd2, 3'd4, 16'd20);
        p[3*32 +: 32] = ins(3'b000, 3'd2, 3'd5, 16'd5);
        p[4*32 +: 32] = ins(3'b011, 3'd3, 3'd7, 16'd10);
        return p;
    endfunction

    function automatic logic [8*32-1:0] regs_a();
        logic [8*32-1:0] r;
        r = '0;
        r[1*32 +: 32] = 32'd36; r[2*32 +: 32] = 32'd9;  r[3*32 +: 32] = 32'd12;
        r[4*32 +: 32] = 32'd18; r[5*32 +: 32] = 32'd7;  r[6*32 +: 32] = 32'd41;
        r[7*32 +: 32] = 32'd22;
        return r;
    endfunction

    function automatic logic [DMD*32-1:0] mem_a();
        logic [DMD*32-1:0] m;
        m = '0;
        m[29*32 +: 32] = 32'd99;
        return m;
    endfunction

    // branch program: untaken beq, taken beq, three trailing adds, two skipped, result add
    function automatic logic [IMD*32-1:0] prog_b();
        logic [IMD*32-1:0] p;
        p = {IMD{NOP}};
        p[0*32 +: 32] = ins(3'b100, 3'd1, 3'd6, 16'd4);
        p[1*32 +: 32] = ins(3'b100, 3'd1, 3'd2, 16'd5);
        p[2*32 +: 32] = ins(3'b000, 3'd1, 3'd2, 16'd3);
        p[3*32 +: 32] = ins(3'b000, 3'd1, 3'd1, 16'd4);
        p[4*32 +: 32] = ins(3'b000, 3'd2, 3'd2, 16'd5);
        p[5*32 +: 32] = ins(3'b001, 3'd1, 3'd1, 16'd6);
        p[6*32 +: 32] = ins(3'b000, 3'd1, 3'd2, 16'd7);
        p[9*32 +: 32] = ins(3'b000, 3'd3, 3'd4, 16'd7);
        return p;
    endfunction

    function automatic logic [8*32-1:0] regs_b();
        logic [8*32-1:0] r;
        r = '0;
        r[1*32 +: 32] = 32'd5; r[2*32 +: 32] = 32'd5;
        r[6*32 +: 32] = 32'd3; r[7*32 +: 32] = 32'd1;
        return r;
    endfunction

    // same-cycle write/read program: lw with negative offset, consumers three slots later
    function automatic logic [IMD*32-1:0] prog_c();
        logic [IMD*32-1:0] p;
        p = {IMD{NOP}};
        p[0*32 +: 32] = ins(3'b010, 3'd2, 3'd4, 16'hFFFD);
        p[3*32 +: 32] = ins(3'b000, 3'd4, 3'd4, 16'd5);
        p[6*32 +: 32] = ins(3'b011, 3'd0, 3'd5, 16'd20);
        return p;
    endfunction

    function automatic logic [8*32-1:0] regs_c();
        logic [8*32-1:0] r;
        r = '0;
        r[2*32 +: 32] = 32'd40;
        return r;
    endfunction

    function automatic logic [DMD*32-1:0] mem_c();
        logic [DMD*32-1:0] m;
        m = '0;
        m[37*32 +: 32] = 32'd1234;
        return m;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  dbg_reg_sel = '0;
    logic [5:0]  dbg_mem_addr = '0;
    logic [31:0] reg_a, reg_b, reg_c, mem_da, mem_db, mem_dc, pc_a, pc_b, pc_c;
    logic        ret_a, ret_b, ret_c;
    int          checks = 0;
    int          failures = 0;

    always #2 clk = ~clk;

    pipe5_core #(.IMEM_DEPTH(IMD), .DMEM_DEPTH(DMD), .PROGRAM(prog_a()),
                 .REG_INIT(regs_a()), .DMEM_INIT(mem_a())) i_pipe5_core (
        .clk(clk), .rst_n(rst_n), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(reg_a),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(mem_da), .dbg_pc(pc_a), .dbg_retire(ret_a));

    pipe5_core #(.IMEM_DEPTH(IMD), .DMEM_DEPTH(DMD), .PROGRAM(prog_b()),
                 .REG_INIT(regs_b()), .DMEM_INIT('0)) i_pipe5_core_br (
        .clk(clk), .rst_n(rst_n), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(reg_b),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(mem_db), .dbg_pc(pc_b), .dbg_retire(ret_b));

    pipe5_core #(.IMEM_DEPTH(IMD), .DMEM_DEPTH(DMD), .PROGRAM(prog_c()),
                 .REG_INIT(regs_c()), .DMEM_INIT(mem_c())) i_pipe5_core_bp (
        .clk(clk), .rst_n(rst_n), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(reg_c),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(mem_dc), .dbg_pc(pc_c), .dbg_retire(ret_c));

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pick(input int r, input int m);
        dbg_reg_sel  = 3'(r);
        dbg_mem_addr = 6'(m);
        #0.2;
    endtask

    // advance k rising edges, then settle at the falling edge
    task automatic adv(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "pc a", pc_a, 0);
        chk("R1", "pc b", pc_b, 0);
        chk("R1", "retire a", 32'(ret_a), 0);
        chk("R1", "retire c", 32'(ret_c), 0);
        pick(1, 29);
        chk("R1", "R1 init", reg_a, 36);
        chk("R11", "mem29 init", mem_da, 99);
        pick(7, 37);
        chk("R1", "R7 init", reg_a, 22);
        chk("R11", "mem37 init", mem_dc, 1234);
    endtask

    task automatic t_sample();
        do_reset();
        adv(3);
        chk("R8", "retire after edge 3", 32'(ret_a), 0);
        adv(1);
        chk("R8", "retire after edge 4", 32'(ret_a), 1);
        pick(3, 0);
        chk("R8", "R3 before its write edge", reg_a, 12);
        adv(1);
        pick(3, 0);
        chk("R3", "add R3 at edge 5", reg_a, 45);
        adv(3);
        chk("R8", "retire after edge 8", 32'(ret_a), 1);
        adv(1);
        chk("R10", "noop in writeback after edge 9", 32'(ret_a), 0);
        adv(3);
        chk("R10", "pc counts past program", pc_a, 12);
        pick(6, 55);
        chk("R3", "nand R6", reg_a, 32'hFFFF_FFFD);
        chk("R5", "store to 55", mem_da, 22);
        pick(5, 29);
        chk("R3", "add R5", reg_a, 16);
        pick(4, 0);
        chk("R4", "load R4", reg_a, 99);
        pick(2, 0);
        chk("R5", "store leaves R2", reg_a, 9);
        pick(1, 0);
        chk("R10", "R1 untouched", reg_a, 36);
    endtask

    task automatic t_branch();
        do_reset();
        adv(4);
        chk("R6", "untaken beq pc after edge 4", pc_b, 4);
        adv(1);
        chk("R7", "taken target pc after edge 5", pc_b, 7);
        adv(11);
        pick(3, 0);
        chk("R7", "trailing add 1 R3", reg_b, 10);
        pick(4, 0);
        chk("R7", "trailing add 2 R4", reg_b, 10);
        pick(5, 0);
        chk("R7", "trailing add 3 R5", reg_b, 10);
        pick(6, 0);
        chk("R6", "skipped nand R6", reg_b, 3);
        pick(7, 0);
        chk("R6", "target add R7", reg_b, 20);
    endtask

    task automatic t_bypass();
        do_reset();
        adv(12);
        pick(4, 37);
        chk("R4", "negative-offset load R4", reg_c, 1234);
        chk("R10", "mem37 unchanged", mem_dc, 1234);
        pick(5, 20);
        chk("R9", "add reads same-cycle load result", reg_c, 2468);
        chk("R9", "store reads same-cycle add result", mem_dc, 2468);
        pick(0, 0);
        chk("R5", "store writes no register R0", reg_c, 0);
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_sample();
        t_branch();
        t_bypass();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule